// File: doc/BRIEF.md
# Thirty-Two-Function Byte Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for an 8-bit datapath. It takes two operand bytes, a carry-in bit and a 5-bit function code, and returns a result byte together with five status flags. The function codes cover:

- constants and pass-through of either operand;
- two's complement negation, increment and decrement;
- add and subtract, with a live carry-in or with a carry forced in;
- a signed-compare subtract;
- both halves of the full product;
- quotient and remainder, including division and remainder by ten;
- three kinds of shift and two rotates through the carry;
- five bitwise functions;
- packed-decimal add and subtract.

The block holds no state. A caller drives the operands and the function code and reads the result and the flags once the logic has settled. Because every output depends only on the inputs, the full behaviour could also be captured as a lookup table.

Top module: `alu32op`

## Requirements
- R1: Codes 0 to 4, 7 and 8 give zero, A, B, the two's complement negation of A (0−A), the negation of B (0−B), B+1 and B−1. For 3, 4 and 8 the carry flag is the borrow. For 7 the carry flag is the carry out of bit 7.
- R2: Code 9 gives A+B+cin, with carry = carry out. Code 10 gives A−B−cin and code 11 gives B−A−cin; for both, carry = 1 exactly when a borrow is needed.
- R3: Codes 13, 14 and 15 give A+B+1, A−B−1 and B−A−1, with the same carry and borrow meaning as R2. The carry-in has no effect on them.
- R4: Code 12 gives A−B and ignores the carry-in. Its carry flag is 1 when A is less than B as signed bytes.
- R5: The overflow flag reports signed two's complement overflow for codes 3, 4 and 7 to 15, and is 0 for every other code.
- R6: Code 16 gives the upper byte of the 16-bit unsigned product A×B. Code 17 gives its lower byte.
- R7: Code 18 gives the unsigned quotient A/B and code 19 the remainder A%B. When B is 0, code 18 gives 0xFF, code 19 gives A, and the divide-by-zero flag is 1. That flag is 0 in every other case.
- R8: Code 5 gives A/10 and code 6 gives A%10, both unsigned.
- R9: Code 20 shifts A left by B places. Code 21 shifts A right arithmetically and code 22 shifts it right logically. For B ≥ 8, codes 20 and 22 give 0 and code 21 gives eight copies of A's bit 7.
- R10: Code 23 rotates the 9-bit value {cin, A} left by B places and code 24 rotates it right. The result is the low 8 bits and the carry flag is the new top bit, so one rotate left sends A bit 7 to the carry and cin to bit 0.
- R11: Codes 25 to 29 give A AND B, A OR B, A XOR B, NOT(A AND B) and NOT B.
- R12: For operands whose two nibbles are each 0 to 9, code 30 gives the packed-decimal value of (A+B+cin) mod 100 with carry = 1 when the sum is 100 or more. Code 31 gives (A−B−cin) mod 100 with carry = 1 when the difference is negative.
- R13: For every code, the zero flag is 1 exactly when the result is 0 and the negative flag equals result bit 7. The carry flag is 0 for codes 0–2, 5, 6, 16–22 and 25–29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | First operand A |
| opnd_b | input | 8 | Second operand B, also the shift and rotate count |
| carry_in | input | 1 | Carry or borrow input |
| op_sel | input | 5 | Function code, 0 to 31 |
| result | output | 8 | Result byte |
| flag_zero | output | 1 | Result is zero |
| flag_neg | output | 1 | Result bit 7 |
| flag_carry | output | 1 | Carry, borrow, rotate carry or signed-less-than, depending on the code |
| flag_ovf | output | 1 | Signed overflow of add and subtract codes |
| flag_divz | output | 1 | Divide or remainder with B equal to zero |

## Verification
Several relations are checked whenever the inputs change:

- the product halves rebuild A×B;
- quotient times divisor plus remainder rebuilds A, with the remainder below B;
- the 9-bit add result and the subtract borrow match plain unsigned arithmetic;
- a divide by zero shows the fixed results;
- XOR undoes itself and large left shifts clear the byte;
- the bitwise codes leave carry and overflow quiet.

Other behaviours cannot be written as a single invariant, so only the bench's scenarios show them:

- rotate counts larger than nine;
- the sign fill of a long arithmetic shift;
- the decimal carry and borrow chains;
- the carry-in being ignored by codes 12 to 15.

The bench compares every code against a reference model over corner and random operand pairs.

// File: rtl/alu32op_pkg.sv
package alu32op_pkg;

  typedef enum logic [4:0] {
    OP_ZERO     = 5'd0,
    OP_PASS_A   = 5'd1,
    OP_PASS_B   = 5'd2,
    OP_NEG_A    = 5'd3,
    OP_NEG_B    = 5'd4,
    OP_DIV10    = 5'd5,
    OP_MOD10    = 5'd6,
    OP_INC_B    = 5'd7,
    OP_DEC_B    = 5'd8,
    OP_ADC      = 5'd9,
    OP_SBC_AB   = 5'd10,
    OP_SBC_BA   = 5'd11,
    OP_CMP_SUB  = 5'd12,
    OP_ADD_ONE  = 5'd13,
    OP_SUB_AB1  = 5'd14,
    OP_SUB_BA1  = 5'd15,
    OP_MUL_HI   = 5'd16,
    OP_MUL_LO   = 5'd17,
    OP_DIV      = 5'd18,
    OP_MOD      = 5'd19,
    OP_SHL      = 5'd20,
    OP_ASR      = 5'd21,
    OP_LSR      = 5'd22,
    OP_ROL_C    = 5'd23,
    OP_ROR_C    = 5'd24,
    OP_AND      = 5'd25,
    OP_OR       = 5'd26,
    OP_XOR      = 5'd27,
    OP_NAND     = 5'd28,
    OP_NOT_B    = 5'd29,
    OP_DEC_ADD  = 5'd30,
    OP_DEC_SUB  = 5'd31
  } op_e;

  // One decimal digit of a sum: returns {carry_out, digit}.
  function automatic logic [4:0] dec_digit_add(input logic [3:0] x,
                                               input logic [3:0] y,
                                               input logic       c);
    logic [4:0] s;
    s = {1'b0, x} + {1'b0, y} + {4'b0000, c};
    if (s > 5'd9) s = s + 5'd6;
    return s;
  endfunction

  // One decimal digit of a difference: returns {borrow_out, digit}.
  function automatic logic [4:0] dec_digit_sub(input logic [3:0] x,
                                               input logic [3:0] y,
                                               input logic       c);
    logic [4:0] d;
    d = {1'b0, x} - {1'b0, y} - {4'b0000, c};
    if (d[4]) return {1'b1, d[3:0] - 4'd6};
    return {1'b0, d[3:0]};
  endfunction

  // Signed two's complement overflow of x + y_eff giving s.
  function automatic logic add_overflow(input logic xm, input logic ym,
                                        input logic sm);
    return (xm == ym) && (sm != xm);
  endfunction

endpackage

// File: rtl/alu32op_addsub.sv
module alu32op_addsub
  import alu32op_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf,
  output logic         slt
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] x, y, y_eff;
  logic         sub, k;   // k: carry for add, borrow for subtract
  logic [W:0]   full;
  logic         c0;

  always_comb begin
    x = '0; y = '0; sub = 1'b0; k = 1'b0;
    unique case (op)
      OP_NEG_A:   begin y = a;                 sub = 1'b1; end
      OP_NEG_B:   begin y = b;                 sub = 1'b1; end
      OP_INC_B:   begin x = b; y = ONE;                    end
      OP_DEC_B:   begin x = b; y = ONE;        sub = 1'b1; end
      OP_ADC:     begin x = a; y = b;                      k = cin;  end
      OP_SBC_AB:  begin x = a; y = b;          sub = 1'b1; k = cin;  end
      OP_SBC_BA:  begin x = b; y = a;          sub = 1'b1; k = cin;  end
      OP_CMP_SUB: begin x = a; y = b;          sub = 1'b1;           end
      OP_ADD_ONE: begin x = a; y = b;                      k = 1'b1; end
      OP_SUB_AB1: begin x = a; y = b;          sub = 1'b1; k = 1'b1; end
      OP_SUB_BA1: begin x = b; y = a;          sub = 1'b1; k = 1'b1; end
      default:    ;
    endcase
  end

  assign y_eff = sub ? ~y : y;
  assign c0    = sub ? ~k : k;
  assign full  = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, c0};
  assign sum   = full[W-1:0];
  assign cout  = sub ? ~full[W] : full[W];
  assign ovf   = add_overflow(x[W-1], y_eff[W-1], sum[W-1]);
  assign slt   = sum[W-1] ^ ovf;

endmodule

// File: rtl/alu32op_muldiv.sv
module alu32op_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic [W-1:0] quot10,
  output logic [W-1:0] rem10,
  output logic         div_zero
);
  localparam logic [W-1:0] TEN = W'(10);

  logic [2*W-1:0] prod;

  assign prod     = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign prod_hi  = prod[2*W-1:W];
  assign prod_lo  = prod[W-1:0];
  assign div_zero = (b == '0);
  assign quot     = div_zero ? '1 : a / b;
  assign rem      = div_zero ? a  : a % b;
  assign quot10   = a / TEN;
  assign rem10    = a % TEN;

endmodule

// File: rtl/alu32op_shift.sv
module alu32op_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] shl,
  output logic [W-1:0] asr,
  output logic [W-1:0] lsr,
  output logic [W-1:0] rol_r,
  output logic         rol_c,
  output logic [W-1:0] ror_r,
  output logic         ror_c
);
  localparam logic [W-1:0] LIM = W'(W);
  localparam logic [W-1:0] RING = W'(W + 1);
  localparam int           EW = W + 1;

  logic             big;
  logic [W-1:0]     amt;
  logic [EW-1:0]    ext;
  logic [2*EW-1:0]  dbl, dl, dr;

  assign big = (b >= LIM);
  assign shl = big ? '0 : (a << b);
  assign lsr = big ? '0 : (a >> b);
  assign asr = big ? {W{a[W-1]}} : W'($signed(a) >>> b);

  // Rotation of the (W+1)-bit ring {cin, a}.
  assign amt   = b % RING;
  assign ext   = {cin, a};
  assign dbl   = {ext, ext};
  assign dl    = dbl << amt;
  assign dr    = dbl >> amt;
  assign rol_r = dl[2*EW-2:EW];
  assign rol_c = dl[2*EW-1];
  assign ror_r = dr[W-1:0];
  assign ror_c = dr[W];

endmodule

// File: rtl/alu32op_bcd.sv
module alu32op_bcd
  import alu32op_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] add_r,
  output logic         add_c,
  output logic [W-1:0] sub_r,
  output logic         sub_c
);
  localparam int DIG = W / 4;

  logic [DIG:0] ca, cb;

  assign ca[0] = cin;
  assign cb[0] = cin;

  for (genvar g = 0; g < DIG; g++) begin : g_digit
    assign {ca[g+1], add_r[4*g +: 4]} = dec_digit_add(a[4*g +: 4], b[4*g +: 4], ca[g]);
    assign {cb[g+1], sub_r[4*g +: 4]} = dec_digit_sub(a[4*g +: 4], b[4*g +: 4], cb[g]);
  end

  assign add_c = ca[DIG];
  assign sub_c = cb[DIG];

endmodule

// File: rtl/alu32op.sv
module alu32op
  import alu32op_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  input  logic [4:0]   op_sel,
  output logic [W-1:0] result,
  output logic         flag_zero,
  output logic         flag_neg,
  output logic         flag_carry,
  output logic         flag_ovf,
  output logic         flag_divz
);
  op_e op;
  assign op = op_e'(op_sel);

  // Named internal results, observed by the bound checker.
  logic [W-1:0] as_sum;
  logic         as_cout, as_ovf, as_slt;
  logic [W-1:0] mul_hi, mul_lo, div_q, div_r, dten_q, dten_r;
  logic         div_zero;
  logic [W-1:0] sh_l, sh_ar, sh_lr, rl_r, rr_r;
  logic         rl_c, rr_c;
  logic [W-1:0] bcd_add, bcd_sub;
  logic         bcd_add_c, bcd_sub_c;
  logic         arith_op;

  alu32op_addsub #(.W(W)) u_addsub (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(carry_in),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf), .slt(as_slt)
  );

  alu32op_muldiv #(.W(W)) u_muldiv (
    .a(opnd_a), .b(opnd_b),
    .prod_hi(mul_hi), .prod_lo(mul_lo), .quot(div_q), .rem(div_r),
    .quot10(dten_q), .rem10(dten_r), .div_zero(div_zero)
  );

  alu32op_shift #(.W(W)) u_shift (
    .a(opnd_a), .b(opnd_b), .cin(carry_in),
    .shl(sh_l), .asr(sh_ar), .lsr(sh_lr),
    .rol_r(rl_r), .rol_c(rl_c), .ror_r(rr_r), .ror_c(rr_c)
  );

  alu32op_bcd #(.W(W)) u_bcd (
    .a(opnd_a), .b(opnd_b), .cin(carry_in),
    .add_r(bcd_add), .add_c(bcd_add_c), .sub_r(bcd_sub), .sub_c(bcd_sub_c)
  );

  always_comb begin
    unique case (op)
      OP_NEG_A, OP_NEG_B, OP_INC_B, OP_DEC_B, OP_ADC, OP_SBC_AB,
      OP_SBC_BA, OP_ADD_ONE, OP_SUB_AB1, OP_SUB_BA1: arith_op = 1'b1;
      default:                                       arith_op = 1'b0;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_ZERO:    result = '0;
      OP_PASS_A:  result = opnd_a;
      OP_PASS_B:  result = opnd_b;
      OP_DIV10:   result = dten_q;
      OP_MOD10:   result = dten_r;
      OP_MUL_HI:  result = mul_hi;
      OP_MUL_LO:  result = mul_lo;
      OP_DIV:     result = div_q;
      OP_MOD:     result = div_r;
      OP_SHL:     result = sh_l;
      OP_ASR:     result = sh_ar;
      OP_LSR:     result = sh_lr;
      OP_ROL_C:   result = rl_r;
      OP_ROR_C:   result = rr_r;
      OP_AND:     result = opnd_a & opnd_b;
      OP_OR:      result = opnd_a | opnd_b;
      OP_XOR:     result = opnd_a ^ opnd_b;
      OP_NAND:    result = ~(opnd_a & opnd_b);
      OP_NOT_B:   result = ~opnd_b;
      OP_DEC_ADD: result = bcd_add;
      OP_DEC_SUB: result = bcd_sub;
      default:    result = as_sum;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_CMP_SUB: flag_carry = as_slt;
      OP_ROL_C:   flag_carry = rl_c;
      OP_ROR_C:   flag_carry = rr_c;
      OP_DEC_ADD: flag_carry = bcd_add_c;
      OP_DEC_SUB: flag_carry = bcd_sub_c;
      default:    flag_carry = arith_op & as_cout;
    endcase
  end

  assign flag_ovf  = (arith_op || op == OP_CMP_SUB) && as_ovf;
  assign flag_divz = (op == OP_DIV || op == OP_MOD) && div_zero;
  assign flag_zero = (result == '0);
  assign flag_neg  = result[W-1];

endmodule

// File: rtl/alu32op_chk.sv
module alu32op_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         carry_in,
  input logic [4:0]   op_sel,
  input logic [W-1:0] result,
  input logic         flag_zero,
  input logic         flag_neg,
  input logic         flag_carry,
  input logic         flag_ovf,
  input logic         flag_divz,
  input logic [W-1:0] mul_hi,
  input logic [W-1:0] mul_lo,
  input logic [W-1:0] div_q,
  input logic [W-1:0] div_r
);
  localparam logic [W-1:0] LIM = W'(W);

  always_comb begin
    assert_mul_rebuild_R6: assert ({mul_hi, mul_lo} ==
        ({{W{1'b0}}, opnd_a} * {{W{1'b0}}, opnd_b}))
      else $error("product halves do not rebuild A*B");

    if (opnd_b != '0) begin
      assert_div_identity_R7: assert ((({{W{1'b0}}, div_q} * {{W{1'b0}}, opnd_b})
          + {{W{1'b0}}, div_r}) == {{W{1'b0}}, opnd_a} && div_r < opnd_b)
        else $error("quotient and remainder inconsistent");
    end

    if (flag_divz) begin
      assert_divz_result_R7: assert (result == ((op_sel == 5'd18) ? {W{1'b1}} : opnd_a))
        else $error("divide-by-zero result wrong");
    end

    if (op_sel == 5'd9) begin
      assert_add_carry_R2: assert ({flag_carry, result} ==
          ({1'b0, opnd_a} + {1'b0, opnd_b} + {{W{1'b0}}, carry_in}))
        else $error("add with carry wrong");
    end

    if (op_sel == 5'd10) begin
      assert_sub_borrow_R2: assert (flag_carry ==
          ({1'b0, opnd_a} < ({1'b0, opnd_b} + {{W{1'b0}}, carry_in})))
        else $error("subtract borrow wrong");
    end

    if (op_sel == 5'd27) begin
      assert_xor_undo_R11: assert ((result ^ opnd_b) == opnd_a)
        else $error("xor result wrong");
    end

    if (op_sel == 5'd20 && opnd_b >= LIM) begin
      assert_shl_clear_R9: assert (result == '0)
        else $error("long left shift not cleared");
    end

    if (op_sel >= 5'd25 && op_sel <= 5'd29) begin
      assert_logic_quiet_R13: assert (!flag_carry && !flag_ovf && !flag_divz)
        else $error("bitwise code raised carry or overflow");
    end

    assert_zero_not_neg_R13: assert (!(flag_zero && flag_neg))
      else $error("zero and negative both set");
  end

endmodule

bind alu32op alu32op_chk #(.W(W)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .op_sel(op_sel),
  .result(result), .flag_zero(flag_zero), .flag_neg(flag_neg),
  .flag_carry(flag_carry), .flag_ovf(flag_ovf), .flag_divz(flag_divz),
  .mul_hi(mul_hi), .mul_lo(mul_lo), .div_q(div_q), .div_r(div_r)
);

// File: tb/test_alu32op.sv
module test_alu32op;

  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic       cin;
  logic [4:0] op;
  logic [7:0] result;
  logic       f_z, f_n, f_c, f_v, f_dz;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  alu32op i_alu32op (
    .opnd_a(a), .opnd_b(b), .carry_in(cin), .op_sel(op),
    .result(result), .flag_zero(f_z), .flag_neg(f_n),
    .flag_carry(f_c), .flag_ovf(f_v), .flag_divz(f_dz)
  );

  // {op, a, b, cin, result, carry, ovf, divz}
  localparam int NV = 26;
  localparam logic [32:0] VEC [NV] = '{
    {5'd9,  8'h7F, 8'h01, 1'b0, 8'h80, 1'b0, 1'b1, 1'b0},
    {5'd10, 8'h00, 8'h01, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0},
    {5'd10, 8'h80, 8'h01, 1'b0, 8'h7F, 1'b0, 1'b1, 1'b0},
    {5'd13, 8'hFF, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    {5'd16, 8'hFF, 8'hFF, 1'b0, 8'hFE, 1'b0, 1'b0, 1'b0},
    {5'd17, 8'hFF, 8'hFF, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0},
    {5'd18, 8'hC8, 8'h07, 1'b0, 8'h1C, 1'b0, 1'b0, 1'b0},
    {5'd19, 8'hC8, 8'h07, 1'b0, 8'h04, 1'b0, 1'b0, 1'b0},
    {5'd18, 8'h35, 8'h00, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b1},
    {5'd19, 8'h35, 8'h00, 1'b0, 8'h35, 1'b0, 1'b0, 1'b1},
    {5'd5,  8'hFF, 8'h00, 1'b0, 8'h19, 1'b0, 1'b0, 1'b0},
    {5'd6,  8'hFF, 8'h00, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0},
    {5'd21, 8'h80, 8'h09, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0},
    {5'd22, 8'h80, 8'h03, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0},
    {5'd23, 8'h80, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    {5'd24, 8'h01, 8'h01, 1'b1, 8'h80, 1'b1, 1'b0, 1'b0},
    {5'd30, 8'h45, 8'h38, 1'b0, 8'h83, 1'b0, 1'b0, 1'b0},
    {5'd30, 8'h99, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    {5'd31, 8'h10, 8'h25, 1'b0, 8'h85, 1'b1, 1'b0, 1'b0},
    {5'd12, 8'h80, 8'h01, 1'b1, 8'h7F, 1'b1, 1'b1, 1'b0},
    {5'd3,  8'h80, 8'h00, 1'b0, 8'h80, 1'b1, 1'b1, 1'b0},
    {5'd28, 8'hF0, 8'h3C, 1'b0, 8'hCF, 1'b0, 1'b0, 1'b0},
    {5'd11, 8'h05, 8'h03, 1'b1, 8'hFD, 1'b1, 1'b0, 1'b0},
    {5'd14, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0},
    {5'd7,  8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    {5'd8,  8'h00, 8'h80, 1'b0, 8'h7F, 1'b0, 1'b1, 1'b0}
  };

  localparam logic [7:0] CORNER [7] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h0A, 8'h09};

  function automatic string tag_of(input int o);
    if (o <= 4 || o == 7 || o == 8) return "R1";
    if (o == 5 || o == 6)           return "R8";
    if (o >= 9 && o <= 11)          return "R2";
    if (o == 12)                    return "R4";
    if (o >= 13 && o <= 15)         return "R3";
    if (o == 16 || o == 17)         return "R6";
    if (o == 18 || o == 19)         return "R7";
    if (o >= 20 && o <= 22)         return "R9";
    if (o == 23 || o == 24)         return "R10";
    if (o >= 25 && o <= 29)         return "R11";
    return "R12";
  endfunction

  function automatic logic [7:0] to_bcd(input logic [7:0] x);
    int v = int'(x) % 100;
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int from_bcd(input logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  // returns {result, carry, overflow}; overflow per R5 from true signed value
  function automatic logic [9:0] ref_add(input int x, input int y, input int sx,
                                         input int sy, input int k);
    int u = x + y + k;
    int s = sx + sy + k;
    logic [7:0] r = u[7:0];
    return {r, u > 255, (s > 127 || s < -128)};
  endfunction

  function automatic logic [9:0] ref_sub(input int x, input int y, input int sx,
                                         input int sy, input int k);
    int u = x - y - k;
    int s = sx - sy - k;
    logic [7:0] r = u[7:0];
    return {r, u < 0, (s > 127 || s < -128)};
  endfunction

  task automatic ref_model(input int o, input logic [7:0] ia, input logic [7:0] ib,
                           input logic ic, output logic [7:0] r, output logic c,
                           output logic v, output logic dz);
    int ua = int'(ia), ub = int'(ib), ci = int'(ic);
    int sa = int'($signed(ia)), sb = int'($signed(ib));
    logic [9:0] t;
    int p, d;
    r = 8'h00; c = 1'b0; v = 1'b0; dz = 1'b0; t = '0;
    case (o)
      0:  r = 8'h00;
      1:  r = ia;
      2:  r = ib;
      3:  t = ref_sub(0, ua, 0, sa, 0);
      4:  t = ref_sub(0, ub, 0, sb, 0);
      5:  r = 8'(ua / 10);
      6:  r = 8'(ua % 10);
      7:  t = ref_add(ub, 1, sb, 1, 0);
      8:  t = ref_sub(ub, 1, sb, 1, 0);
      9:  t = ref_add(ua, ub, sa, sb, ci);
      10: t = ref_sub(ua, ub, sa, sb, ci);
      11: t = ref_sub(ub, ua, sb, sa, ci);
      12: t = ref_sub(ua, ub, sa, sb, 0);
      13: t = ref_add(ua, ub, sa, sb, 1);
      14: t = ref_sub(ua, ub, sa, sb, 1);
      15: t = ref_sub(ub, ua, sb, sa, 1);
      16: begin p = ua * ub; r = 8'(p / 256); end
      17: begin p = ua * ub; r = 8'(p % 256); end
      18: begin dz = (ub == 0); r = dz ? 8'hFF : 8'(ua / ub); end
      19: begin dz = (ub == 0); r = dz ? ia : 8'(ua % ub); end
      20: r = (ub >= 8) ? 8'h00 : 8'((ua * (1 << ub)) % 256);
      21: begin r = ia; for (int i = 0; i < ub && i < 8; i++) r = {r[7], r[7:1]}; end
      22: r = (ub >= 8) ? 8'h00 : 8'(ua / (1 << ub));
      23: begin
        logic nc; r = ia; c = ic;
        for (int i = 0; i < ub; i++) begin nc = r[7]; r = {r[6:0], c}; c = nc; end
      end
      24: begin
        logic nc; r = ia; c = ic;
        for (int i = 0; i < ub; i++) begin nc = r[0]; r = {c, r[7:1]}; c = nc; end
      end
      25: r = ia & ib;
      26: r = ia | ib;
      27: r = ia ^ ib;
      28: r = ~(ia & ib);
      29: r = ~ib;
      30: begin
        d = from_bcd(ia) + from_bcd(ib) + ci;
        c = (d >= 100); r = to_bcd(8'(d % 100));
      end
      default: begin
        d = from_bcd(ia) - from_bcd(ib) - ci;
        c = (d < 0); if (d < 0) d = d + 100; r = to_bcd(8'(d));
      end
    endcase
    if ((o >= 3 && o <= 4) || (o >= 7 && o <= 15)) begin
      r = t[9:2]; c = t[1]; v = t[0];
      if (o == 12) c = (sa < sb);   // R4 signed less-than
    end
  endtask

  task automatic run(input logic [4:0] o, input logic [7:0] ia, input logic [7:0] ib,
                     input logic ic, input logic [7:0] er, input logic ec,
                     input logic ev, input logic edz, input string tag);
    @(posedge clk);
    #1;
    op = o; a = ia; b = ib; cin = ic;
    @(negedge clk);
    checks++;
    // R13: zero and negative follow the expected result
    if (result !== er || f_z !== (er == 8'h00) || f_n !== er[7] ||
        f_c !== ec || f_v !== ev || f_dz !== edz) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%b: got r=%h z%b n%b c%b v%b dz%b exp r=%h z%b n%b c%b v%b dz%b",
               tag, o, ia, ib, ic, result, f_z, f_n, f_c, f_v, f_dz,
               er, (er == 8'h00), er[7], ec, ev, edz);
    end
  endtask

  task automatic run_ref(input int o, input logic [7:0] ia, input logic [7:0] ib,
                         input logic ic);
    logic [7:0] r, xa, xb;
    logic c, v, dz;
    xa = ia; xb = ib;
    if (o >= 30) begin xa = to_bcd(ia); xb = to_bcd(ib); end
    ref_model(o, xa, xb, ic, r, c, v, dz);
    run(5'(o), xa, xb, ic, r, c, v, dz, tag_of(o));
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op = 5'd0; a = 8'h00; b = 8'h00; cin = 1'b0;
    repeat (3) @(posedge clk);

    // Idle state: code 0 with all-zero operands (R1, R13)
    run(5'd0, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R1 idle");

    // Hand-computed vector table
    for (int i = 0; i < NV; i++) begin
      logic [32:0] e = VEC[i];
      run(e[32:28], e[27:20], e[19:12], e[11], e[10:3], e[2], e[1], e[0],
          {tag_of(int'(e[32:28])), " table"});
    end

    // R4 and R3: carry-in has no effect on codes 12 to 15
    run(5'd12, 8'h05, 8'h05, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R4 cin ignored");
    run(5'd13, 8'h01, 8'h01, 1'b0, 8'h03, 1'b0, 1'b0, 1'b0, "R3 forced carry");
    // R10: count above nine wraps the 9-bit ring (10 == 1 step)
    run(5'd23, 8'h80, 8'h0A, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R10 wrap");
    // R9: long arithmetic shift of a positive value
    run(5'd21, 8'h7F, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R9 sign fill");
    // R5 and R13: quiet flags on a bitwise code
    run(5'd26, 8'h80, 8'h01, 1'b1, 8'h81, 1'b0, 1'b0, 1'b0, "R13 quiet");

    // Every code over corner operand pairs and both carry-in values
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          for (int k = 0; k < 2; k++)
            run_ref(o, CORNER[i], CORNER[j], k[0]);

    // Every code over random operand pairs (R5 overflow through reference)
    for (int o = 0; o < 32; o++)
      for (int n = 0; n < 32; n++)
        run_ref(o, 8'($urandom), 8'($urandom), 1'($urandom));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule